// File: doc/BRIEF.md
# Camera Frame Output Sequencer

This block drives the parallel video port of an area-scan camera toward a frame grabber. An edge on the trigger input starts a sensor integration phase. The shutter output is high for exactly that phase, so an external flash can be lit in step with the exposure. The integration ends after a programmed count of clocks, or, when the control input selects external exposure, when the exposure input drops. On the next clock the block opens a frame and reads out a fixed grid of pixels. It qualifies them with a frame-valid and a line-valid output, and it presents them on a 16-bit bus that is timed to a pixel clock output.

The frame width and height are parameters. The exposure length, the lead time of frame-valid before the first line and the blanking gap between lines are register inputs, which are held steady while a frame runs. Pixel values come from a sensor input. They are registered onto the bus, and an 8-bit mode clears bits 9 and 8.

Top module: `cam_frame_seq`

## Requirements
- R1: During reset and in the first cycle after it, shutter_o, frame_valid_o, line_valid_o and every bit of pix_data_o are low.
- R2: When the block is idle and trig_i goes from 0 to 1 at a clock edge, shutter_o is high starting from that edge.
- R3: With ext_exp_sel_i = 0, shutter_o stays high for exactly exp_clocks_i cycles. A value of 0 is treated as 1.
- R4: With ext_exp_sel_i = 1, shutter_o stays high until the first clock edge at which exp_gate_i is low. The minimum is one cycle.
- R5: frame_valid_o rises at the same edge at which shutter_o falls. shutter_o and frame_valid_o are never high together. line_valid_o first rises fv_lead_i cycles after frame_valid_o, or at the same edge when fv_lead_i = 0.
- R6: A frame holds FRAME_H lines. Each line has line_valid_o high for FRAME_W consecutive cycles. Consecutive lines are separated by hblank_i cycles with line_valid_o low and frame_valid_o high. frame_valid_o falls in the cycle after the last pixel. line_valid_o is never high while frame_valid_o is low.
- R7: A trigger edge during integration or readout is ignored. A trigger level that is held high does not start a new frame when the block returns to idle.
- R8: In a line_valid_o cycle, pix_data_o[9:0] equals the value sensor_pix_i had at the clock edge that began that cycle. Bits 15:10 are always 0.
- R9: With mode8_i = 1, bits 9 and 8 of pix_data_o are 0, and bits 7:0 follow sensor_pix_i[7:0].
- R10: pix_data_o is all zero in every cycle in which line_valid_o is low.
- R11: pix_clk_o is the inverse of clk, so pix_data_o changes only on a falling edge of pix_clk_o and is stable at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | External trigger. A rising edge starts integration |
| exp_gate_i | input | 1 | External exposure level |
| ext_exp_sel_i | input | 1 | Control input. 1 selects external exposure control |
| mode8_i | input | 1 | 1 selects 8-bit output |
| exp_clocks_i | input | CNT_W | Programmed integration length in clocks |
| fv_lead_i | input | CNT_W | Clocks of frame-valid before the first line |
| hblank_i | input | CNT_W | Blanking clocks between lines |
| sensor_pix_i | input | PIX_W | Pixel value from the sensor |
| shutter_o | output | 1 | High during integration |
| frame_valid_o | output | 1 | High during a frame transfer |
| line_valid_o | output | 1 | High during the pixels of a line |
| pix_clk_o | output | 1 | Pixel clock |
| pix_data_o | output | BUS_W | Pixel data bus |

## Verification
The bench aims at the zero settings: exposure count 0, lead 0 and blanking 0. A design that mishandled these would hang in a state, lose a cycle, or leave a stray blank cycle between lines. It drives trigger noise through integration and readout, and it holds the trigger high across a whole frame. A design that accepted a busy trigger would restart integration or reopen a frame after the last line. It also checks every pixel against the value sampled one edge earlier, in both data modes. An off-by-one pipeline would show shifted pixels, and a wrong mask would leak bits 9 and 8 in 8-bit mode or non-zero data in blanking.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPOSE,
        ST_LEAD,
        ST_LINE,
        ST_HBLANK
    } seq_state_t;
endpackage

// File: rtl/cfs_edge.sv
module cfs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cfs_fmt.sv
module cfs_fmt #(
    parameter int PIX_W = 10,
    parameter int BUS_W = 16
) (
    input  logic [PIX_W-1:0] pix_i,
    input  logic             mode8_i,
    output logic [BUS_W-1:0] bus_o
);
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        if (i >= PIX_W) begin : g_unused
            assign bus_o[i] = 1'b0;
        end else if (i >= 8) begin : g_upper
            assign bus_o[i] = pix_i[i] & ~mode8_i;
        end else begin : g_lower
            assign bus_o[i] = pix_i[i];
        end
    end
endmodule

// File: rtl/cam_frame_seq.sv
module cam_frame_seq
    import cfs_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    parameter int PIX_W   = 10,
    parameter int BUS_W   = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             exp_gate_i,
    input  logic             ext_exp_sel_i,
    input  logic             mode8_i,
    input  logic [CNT_W-1:0] exp_clocks_i,
    input  logic [CNT_W-1:0] fv_lead_i,
    input  logic [CNT_W-1:0] hblank_i,
    input  logic [PIX_W-1:0] sensor_pix_i,
    output logic             shutter_o,
    output logic             frame_valid_o,
    output logic             line_valid_o,
    output logic             pix_clk_o,
    output logic [BUS_W-1:0] pix_data_o
);
    localparam int COL_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int ROW_W = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FRAME_H - 1);

    typedef struct packed {
        seq_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [BUS_W-1:0] dat;
    } seq_t;

    seq_t s_d, s_q;
    logic trig_rise;
    logic [BUS_W-1:0] fmt_bus;
    logic [CNT_W-1:0] exp_last;
    logic exp_done;

    cfs_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (trig_i),
        .rise_o (trig_rise)
    );

    cfs_fmt #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_fmt (
        .pix_i   (sensor_pix_i),
        .mode8_i (mode8_i),
        .bus_o   (fmt_bus)
    );

    always_comb begin
        s_d      = s_q;
        exp_last = (exp_clocks_i == '0) ? '0 : exp_clocks_i - 1'b1;
        exp_done = ext_exp_sel_i ? ~exp_gate_i : (s_q.cnt >= exp_last);
        case (s_q.st)
            ST_IDLE: begin
                if (trig_rise) begin
                    s_d.st  = ST_EXPOSE;
                    s_d.cnt = '0;
                end
            end
            ST_EXPOSE: begin
                if (exp_done) begin
                    s_d.cnt = '0;
                    s_d.col = '0;
                    s_d.row = '0;
                    s_d.st  = (fv_lead_i == '0) ? ST_LINE : ST_LEAD;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_LEAD: begin
                if (s_q.cnt == fv_lead_i - 1'b1) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_LINE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_LINE: begin
                if (s_q.col == COL_LAST) begin
                    s_d.col = '0;
                    s_d.cnt = '0;
                    if (s_q.row == ROW_LAST) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.row = s_q.row + 1'b1;
                        s_d.st  = (hblank_i == '0) ? ST_LINE : ST_HBLANK;
                    end
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
            ST_HBLANK: begin
                if (s_q.cnt == hblank_i - 1'b1) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_LINE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        s_d.dat = (s_d.st == ST_LINE) ? fmt_bus : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.cnt <= '0;
            s_q.col <= '0;
            s_q.row <= '0;
            s_q.dat <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign shutter_o     = (s_q.st == ST_EXPOSE);
    assign line_valid_o  = (s_q.st == ST_LINE);
    assign frame_valid_o = (s_q.st == ST_LEAD) || (s_q.st == ST_LINE) || (s_q.st == ST_HBLANK);
    assign pix_clk_o     = ~clk;
    assign pix_data_o    = s_q.dat;

    // R6: line qualifier only inside a frame
    a_r6_lv_in_fv: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> frame_valid_o);
    // R5: readout begins on the edge integration ends
    a_r5_fv_after_shutter: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutter_o) |-> frame_valid_o);
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutter_o && frame_valid_o));
    // R7: a running frame never restarts integration
    a_r7_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !shutter_o);
    // R10: blanked data
    a_r10_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid_o |-> (pix_data_o == '0));
    // R9: 8-bit mode clears the top two pixel bits
    a_r9_mode8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode8_i) && line_valid_o) |-> (pix_data_o[9:8] == 2'b00));
endmodule

// File: tb/tb_cam_frame_seq.sv
module tb_cam_frame_seq;
    localparam int W = 5;
    localparam int H = 3;
    localparam int PW = 10;
    localparam int BW = 16;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0, gate = 1'b0, extsel = 1'b0, m8 = 1'b0;
    logic [CW-1:0] expc = '0, lead = '0, hb = '0;
    logic [PW-1:0] pix = '0;
    logic sh, fv, lv, pclk;
    logic [BW-1:0] dat;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [PW-1:0] last_pix = '0;
    bit noise = 1'b0;

    always #10 clk = ~clk;

    cam_frame_seq #(.FRAME_W(W), .FRAME_H(H), .PIX_W(PW), .BUS_W(BW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .exp_gate_i(gate),
        .ext_exp_sel_i(extsel), .mode8_i(m8), .exp_clocks_i(expc),
        .fv_lead_i(lead), .hblank_i(hb), .sensor_pix_i(pix),
        .shutter_o(sh), .frame_valid_o(fv), .line_valid_o(lv),
        .pix_clk_o(pclk), .pix_data_o(dat)
    );

    function automatic logic [BW-1:0] fmt(logic [PW-1:0] p, bit mode8);
        logic [BW-1:0] r;
        r = {{(BW-PW){1'b0}}, p};
        if (mode8) r[9:8] = 2'b00;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_cyc(bit esh, bit efv, bit elv, logic [BW-1:0] ed, string tag);
        chk(sh == esh, {tag, " shutter"}, BW'(sh), BW'(esh));
        chk(fv == efv, {tag, " frame_valid"}, BW'(fv), BW'(efv));
        chk(lv == elv, {tag, " line_valid"}, BW'(lv), BW'(elv));
        chk(dat == ed, {tag, " data"}, dat, ed);
        chk(pclk == 1'b1, "R11 pix_clk", BW'(pclk), 1);
        pix = PW'($urandom);
        last_pix = pix;
        if (noise) trig = 1'($urandom);
    endtask

    task automatic run_frame(int e, int ld, int hbl, bit mode8, bit ext, int glen, bit nz);
        int nexp;
        expc = CW'(e); lead = CW'(ld); hb = CW'(hbl); m8 = mode8; extsel = ext;
        trig = 1'b0;
        tick();
        expect_cyc(0, 0, 0, '0, "R1 idle");
        trig = 1'b1;
        gate = ext;
        noise = nz;
        nexp = ext ? glen : ((e == 0) ? 1 : e);
        for (int i = 0; i < nexp; i++) begin
            tick();
            expect_cyc(1, 0, 0, '0, ext ? "R4 R2 expose" : "R3 R2 expose");
            if (ext && i == nexp - 1) gate = 1'b0;
        end
        for (int i = 0; i < ld; i++) begin
            tick();
            expect_cyc(0, 1, 0, '0, "R5 lead");
        end
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                logic [PW-1:0] sp;
                sp = last_pix;
                tick();
                expect_cyc(0, 1, 1, fmt(sp, mode8), mode8 ? "R9 pixel" : "R8 pixel");
            end
            if (r < H - 1) begin
                for (int i = 0; i < hbl; i++) begin
                    tick();
                    expect_cyc(0, 1, 0, '0, "R6 R10 hblank");
                end
            end
        end
        noise = 1'b0;
        if (!nz) trig = 1'b1; else trig = 1'b0;
        for (int i = 0; i < 2; i++) begin
            tick();
            expect_cyc(0, 0, 0, '0, "R6 R7 after frame");
        end
        trig = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7731));
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_cyc(0, 0, 0, '0, "R1 in reset");
        end
        rst_n = 1'b1;
        tick();
        expect_cyc(0, 0, 0, '0, "R1 after reset");
        @(posedge clk); #1;
        chk(pclk == 1'b0, "R11 pix_clk low", BW'(pclk), 0);
        // directed corners
        run_frame(0, 0, 0, 0, 0, 1, 0);
        run_frame(1, 1, 1, 1, 0, 1, 1);
        run_frame(4, 2, 3, 0, 1, 1, 0);
        run_frame(3, 0, 2, 1, 1, 4, 1);
        for (int k = 0; k < 14; k++) begin
            run_frame(int'($urandom_range(0, 6)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                      int'($urandom_range(1, 4)), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule